// File: doc/BRIEF.md
# Dual-Channel Bus Breakpoint Comparator

This debug block watches every cycle on a processor bus and asks for a break when a cycle meets the conditions programmed into one of its two channels. Each channel holds a compare address, an address mask, a cycle-condition word and an address-space identifier (ASID). The second channel also compares bus data against a data word under a data mask. The channels run independently, so a hit on either one raises the break request.

An instruction-fetch hit can be taken before or after execution. A before-execution hit drives the break output in the same cycle as the fetch. An after-execution hit waits as a pending request. It fires on the next instruction-retire strobe. Software programs the block through a single-cycle write port. It reads each channel's sticky hit flag and clears the flag through that same port.

The bus input is a monitor tap. `bus_valid` qualifies each descriptor, and there is no ready signal. The block can never stall the bus, so it samples every valid cycle. Control and status pins are plain levels.

Top module: `brk_cmp_top`

## Requirements
- R1: Channels are independent. `brk_req` is high in any cycle in which channel A fires, channel B fires, or both fire.
- R2: An address bit is compared only where the channel's address mask bit is 0. With base 0x8010 and mask 0x6, addresses 0x8010, 0x8012, 0x8014 and 0x8016 hit. Addresses 0x8011 and 0x8018 do not.
- R3: Condition word bits select which cycles can hit. Bit 0 enables CPU-master cycles, bit 1 other-master cycles, bit 2 instruction fetches, bit 3 data accesses, bit 4 reads and bit 5 writes. A cycle hits only when its master, its access type and its direction are each enabled.
- R4: Condition bit 7 enables the size check. When bit 7 is 0, `bus_size` has no effect. When bit 7 is 1, `bus_size` must equal condition bits 9:8.
- R5: With condition bit 6 at 0, a matching cycle (fetch or data) drives `brk_req` high combinationally in the same cycle.
- R6: With condition bit 6 at 1, a matching fetch does not break in its own cycle. It sets a pending request. `brk_req` then goes high in the first later cycle with `ret_valid`, and that retire consumes the pending request. Bit 6 has no effect on data cycles.
- R7: Condition bit 10 enables the ASID check. When bit 10 is 0, `bus_asid` is ignored. When bit 10 is 1, `bus_asid` must equal the channel's ASID register.
- R8: On data-access cycles, channel B also requires the bus data to equal its data register on every bit where the data mask is 0. A zero mask compares all bits. Bus data is never compared on fetch cycles.
- R9: Each channel's hit flag (`hit_a`, `hit_b`) sets on the clock edge after the channel fires and stays set. Writing register 10 clears the flag of A (bit 0) and of B (bit 1). A fire in the same cycle as a clear wins.
- R10: A channel whose condition word enables no master, no access type or no direction never fires. A cycle with `bus_valid` low never hits.
- R11: After reset, all registers, pending requests and flags are zero. Register map: A at 0 to 3 and B at 4 to 7, in the order address, address mask, condition, ASID. B data is at 8, B data mask at 9 and the flag clear at 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | DW | Register write data |
| bus_valid | input | 1 | Bus descriptor valid this cycle |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus data |
| bus_cpu | input | 1 | 1 = CPU master, 0 = other master |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Operand size code |
| bus_asid | input | IW | Address-space identifier |
| ret_valid | input | 1 | Instruction retire strobe |
| brk_req | output | 1 | Break request (combinational) |
| hit_a | output | 1 | Sticky hit flag, channel A |
| hit_b | output | 1 | Sticky hit flag, channel B |

## Verification
The bench builds the block with the defaults: 32-bit address and data and 8-bit ASIDs. Because the width is the full 32 bits, the address 0x404 and the 0x8010 range can be driven exactly as written, alongside random addresses. The random bus addresses and data differ from the programmed values only in their low bits. Together with small random masks, this makes hits, masked-out differences and near misses all frequent. The retire strobe is random, so pending after-execution requests meet retires both immediately and after several idle cycles.

// File: rtl/brk_pkg.sv
package brk_pkg;
  // Condition word, LSB first: cpu, other, fetch, data, rd, wr, after, size_chk, size[1:0], asid_chk
  typedef struct packed {
    logic       asid_chk;
    logic [1:0] size;
    logic       size_chk;
    logic       after;
    logic       en_wr;
    logic       en_rd;
    logic       en_data;
    logic       en_fetch;
    logic       en_oth;
    logic       en_cpu;
  } cond_t;

  localparam int COND_W   = $bits(cond_t);
  localparam int REG_AW   = 4;
  localparam int CH_STRIDE = 4;
  localparam int OFS_ADDR = 0;
  localparam int OFS_MASK = 1;
  localparam int OFS_COND = 2;
  localparam int OFS_ASID = 3;
  localparam int REG_DATA = 8;
  localparam int REG_DMSK = 9;
  localparam int REG_CLR  = 10;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 8,
  parameter int NCH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [REG_AW-1:0]         waddr,
  input  logic [DW-1:0]             wdata,
  output logic [NCH-1:0][AW-1:0]    c_addr,
  output logic [NCH-1:0][AW-1:0]    c_amask,
  output cond_t [NCH-1:0]           c_cond,
  output logic [NCH-1:0][IW-1:0]    c_asid,
  output logic [DW-1:0]             c_data,
  output logic [DW-1:0]             c_dmask,
  output logic [NCH-1:0]            clr
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int BASE = ch * CH_STRIDE;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_addr[ch]  <= '0;
        c_amask[ch] <= '0;
        c_cond[ch]  <= '0;
        c_asid[ch]  <= '0;
      end else if (we) begin
        if (waddr == REG_AW'(BASE + OFS_ADDR)) c_addr[ch]  <= wdata[AW-1:0];
        if (waddr == REG_AW'(BASE + OFS_MASK)) c_amask[ch] <= wdata[AW-1:0];
        if (waddr == REG_AW'(BASE + OFS_COND)) c_cond[ch]  <= cond_t'(wdata[COND_W-1:0]);
        if (waddr == REG_AW'(BASE + OFS_ASID)) c_asid[ch]  <= wdata[IW-1:0];
      end
    end
    assign clr[ch] = we && (waddr == REG_AW'(REG_CLR)) && wdata[ch];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_data  <= '0;
      c_dmask <= '0;
    end else if (we) begin
      if (waddr == REG_AW'(REG_DATA)) c_data  <= wdata;
      if (waddr == REG_AW'(REG_DMSK)) c_dmask <= wdata;
    end
  end
endmodule

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 8,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] c_addr,
  input  logic [AW-1:0] c_amask,
  input  cond_t         c_cond,
  input  logic [IW-1:0] c_asid,
  input  logic [DW-1:0] c_data,
  input  logic [DW-1:0] c_dmask,
  input  logic          clr,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_cpu,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  input  logic [IW-1:0] bus_asid,
  input  logic          ret_valid,
  output logic          fire,
  output logic          flag
);
  logic master_ok, type_ok, dir_ok, size_ok, asid_ok, addr_ok, data_ok;
  logic cyc_ok, delayed, now_hit, pend_q;

  assign master_ok = bus_cpu   ? c_cond.en_cpu   : c_cond.en_oth;
  assign type_ok   = bus_fetch ? c_cond.en_fetch : c_cond.en_data;
  assign dir_ok    = bus_write ? c_cond.en_wr    : c_cond.en_rd;
  assign size_ok   = !c_cond.size_chk || (bus_size == c_cond.size);
  assign asid_ok   = !c_cond.asid_chk || (bus_asid == c_asid);
  assign addr_ok   = ((bus_addr ^ c_addr) & ~c_amask) == '0;

  if (HAS_DATA) begin : g_data
    assign data_ok = bus_fetch || (((bus_data ^ c_data) & ~c_dmask) == '0);
  end else begin : g_nodata
    assign data_ok = 1'b1;
  end

  assign cyc_ok  = bus_valid && master_ok && type_ok && dir_ok &&
                   size_ok && asid_ok && addr_ok && data_ok;
  assign delayed = bus_fetch && c_cond.after;
  assign now_hit = cyc_ok && !delayed;
  assign fire    = now_hit || (pend_q && ret_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      pend_q <= (pend_q && !ret_valid) || (cyc_ok && delayed);
      flag   <= fire || (flag && !clr);
    end
  end

  assert_no_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_cond.en_cpu && !c_cond.en_oth) |-> !now_hit);
  assert_after_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_fetch && c_cond.after && !pend_q) |-> !fire);
  assert_pend_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cyc_ok && delayed) && ret_valid) |-> fire);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag) && !$past(clr)) |-> flag);
  assert_flag_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag);
endmodule

// File: rtl/brk_cmp_top.sv
module brk_cmp_top
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              bus_valid,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_data,
  input  logic              bus_cpu,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [IW-1:0]     bus_asid,
  input  logic              ret_valid,
  output logic              brk_req,
  output logic              hit_a,
  output logic              hit_b
);
  localparam int NCH = 2;

  logic [NCH-1:0][AW-1:0] c_addr, c_amask;
  cond_t [NCH-1:0]        c_cond;
  logic [NCH-1:0][IW-1:0] c_asid;
  logic [DW-1:0]          c_data, c_dmask;
  logic [NCH-1:0]         clr, fire, flag;

  brk_regs #(.AW(AW), .DW(DW), .IW(IW), .NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .c_addr(c_addr), .c_amask(c_amask), .c_cond(c_cond), .c_asid(c_asid),
    .c_data(c_data), .c_dmask(c_dmask), .clr(clr)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    brk_chan #(.AW(AW), .DW(DW), .IW(IW), .HAS_DATA(ch == 1)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .c_addr(c_addr[ch]), .c_amask(c_amask[ch]), .c_cond(c_cond[ch]),
      .c_asid(c_asid[ch]), .c_data(c_data), .c_dmask(c_dmask), .clr(clr[ch]),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_cpu(bus_cpu), .bus_fetch(bus_fetch), .bus_write(bus_write),
      .bus_size(bus_size), .bus_asid(bus_asid), .ret_valid(ret_valid),
      .fire(fire[ch]), .flag(flag[ch])
    );
  end

  assign brk_req = |fire;
  assign hit_a   = flag[0];
  assign hit_b   = flag[1];

  assert_req_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> (hit_a || hit_b));
  assert_invalid_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && !ret_valid) |-> !brk_req);
endmodule

// File: tb/brk_cmp_top_bench.sv
module brk_cmp_top_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_we = 0;
  logic [3:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        bus_valid = 0, bus_cpu = 0, bus_fetch = 0, bus_write = 0, ret_valid = 0;
  logic [31:0] bus_addr = 0, bus_data = 0;
  logic [1:0]  bus_size = 0;
  logic [7:0]  bus_asid = 0;
  logic        brk_req, hit_a, hit_b;

  brk_cmp_top u_brk_cmp_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data), .bus_cpu(bus_cpu),
    .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_size(bus_size), .bus_asid(bus_asid),
    .ret_valid(ret_valid), .brk_req(brk_req), .hit_a(hit_a), .hit_b(hit_b)
  );

  int checks = 0, errors = 0;
  logic [31:0] m_addr [2], m_amask [2], m_asid [2];
  logic [10:0] m_cond [2];
  logic [31:0] m_data = 0, m_dmask = 0;
  logic m_pend [2], m_flag [2];
  logic last_brk;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic m_ok(input int ch);
    logic [10:0] c = m_cond[ch];
    logic ok;
    ok = bus_valid && (bus_cpu ? c[0] : c[1]) && (bus_fetch ? c[2] : c[3]) &&
         (bus_write ? c[5] : c[4]) && (!c[7] || bus_size == c[9:8]) &&
         (!c[10] || bus_asid == m_asid[ch][7:0]) &&
         (((bus_addr ^ m_addr[ch]) & ~m_amask[ch]) == 0);
    if (ch == 1 && !bus_fetch) ok = ok && (((bus_data ^ m_data) & ~m_dmask) == 0);
    return ok;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; bus_valid = 0; ret_valid = 0;
    @(posedge clk);
    case (a)
      0: m_addr[0] = d;  1: m_amask[0] = d; 2: m_cond[0] = d[10:0]; 3: m_asid[0] = d;
      4: m_addr[1] = d;  5: m_amask[1] = d; 6: m_cond[1] = d[10:0]; 7: m_asid[1] = d;
      8: m_data = d;     9: m_dmask = d;
      10: begin if (d[0]) m_flag[0] = 0; if (d[1]) m_flag[1] = 0; end
      default: ;
    endcase
    #1 cfg_we = 0;
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] d,
                      input logic cpu, input logic f, input logic w,
                      input logic [1:0] sz, input logic [7:0] as, input logic rt);
    logic ok [2], del [2], ex [2];
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_data = d; bus_cpu = cpu; bus_fetch = f;
    bus_write = w; bus_size = sz; bus_asid = as; ret_valid = rt;
    #1;
    for (int ch = 0; ch < 2; ch++) begin
      ok[ch]  = m_ok(ch);
      del[ch] = f && m_cond[ch][6];
      ex[ch]  = (ok[ch] && !del[ch]) || (m_pend[ch] && rt);
    end
    last_brk = brk_req;
    chk(brk_req, ex[0] || ex[1], "R1/R2/R3/R5/R6 brk_req");
    @(posedge clk);
    for (int ch = 0; ch < 2; ch++) begin
      m_pend[ch] = (m_pend[ch] && !rt) || (ok[ch] && del[ch]);
      m_flag[ch] = m_flag[ch] || ex[ch];
    end
    #1;
    chk(hit_a, m_flag[0], "R9 hit_a");
    chk(hit_b, m_flag[1], "R9 hit_b");
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int ch = 0; ch < 2; ch++) begin
      m_addr[ch] = 0; m_amask[ch] = 0; m_cond[ch] = 0; m_asid[ch] = 0;
      m_pend[ch] = 0; m_flag[ch] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(brk_req, 0, "R11 reset brk_req");
    chk(hit_a, 0, "R11 reset hit_a");
    chk(hit_b, 0, "R11 reset hit_b");
    rst_n = 1;

    // R10: reset config, all enables zero, fetch at 0 must not hit
    step(1, 0, 0, 1, 1, 0, 0, 0, 0);
    chk(last_brk, 0, "R10 no enables");

    // R6: channel A at 0x404, fetch/after/read on CPU
    wr(0, 32'h404); wr(1, 0); wr(2, 32'h55);
    step(1, 32'h404, 0, 1, 1, 0, 0, 0, 0);
    chk(last_brk, 0, "R6 no break at fetch");
    idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk(last_brk, 1, "R6 break on retire");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk(last_brk, 0, "R6 pending consumed");

    // R9: clear A flag
    wr(10, 1); idle();
    chk(hit_a, 0, "R9 clear");

    // R2/R5: channel B 0x8010 mask 6 fetch before
    wr(4, 32'h8010); wr(5, 32'h6); wr(6, 32'h15);
    step(1, 32'h8016, 32'hdead, 1, 1, 0, 0, 0, 0);
    chk(last_brk, 1, "R5/R2 0x8016 same cycle, data ignored on fetch R8");
    step(1, 32'h8011, 0, 1, 1, 0, 0, 0, 0);
    chk(last_brk, 0, "R2 0x8011 miss");
    step(1, 32'h8018, 0, 1, 1, 0, 0, 0, 0);
    chk(last_brk, 0, "R2 0x8018 miss");
    step(1, 32'h8016, 0, 1, 1, 1, 0, 0, 0);
    chk(last_brk, 0, "R3 write not enabled");

    // R8: data compare on B
    wr(6, 32'h29); wr(8, 32'h12345600); wr(9, 32'hff);
    step(1, 32'h8010, 32'h123456ab, 1, 0, 1, 0, 0, 0);
    chk(last_brk, 1, "R8 masked data hit");
    step(1, 32'h8010, 32'h123457ab, 1, 0, 1, 0, 0, 0);
    chk(last_brk, 0, "R8 data miss");

    // R7/R4: channel A data read with asid and size checks
    wr(2, 32'h019 | (1 << 10) | (1 << 7) | (2 << 8)); wr(3, 5);
    step(1, 32'h404, 0, 1, 0, 0, 2, 6, 0);
    chk(last_brk, 0, "R7 asid miss");
    step(1, 32'h404, 0, 1, 0, 0, 2, 5, 0);
    chk(last_brk, 1, "R7 asid hit");
    step(1, 32'h404, 0, 1, 0, 0, 1, 5, 0);
    chk(last_brk, 0, "R4 size mismatch");
    wr(2, 32'h019);
    step(1, 32'h404, 0, 1, 0, 0, 1, 9, 0);
    chk(last_brk, 1, "R4/R7 checks off");

    // Random phase
    for (int blk = 0; blk < 15; blk++) begin
      for (int ch = 0; ch < 2; ch++) begin
        wr(4'(ch * 4 + 0), $urandom);
        wr(4'(ch * 4 + 1), $urandom & 32'h7);
        wr(4'(ch * 4 + 2), ($urandom & 32'h7c0) | ($urandom | ($urandom & 32'h3f)) & 32'h3f);
        wr(4'(ch * 4 + 3), $urandom & 32'h3);
      end
      wr(8, $urandom); wr(9, $urandom & 32'hf);
      if ($urandom % 2 == 0) wr(10, 3);
      for (int i = 0; i < 200; i++) begin
        int ch = $urandom % 2;
        logic [31:0] a = m_addr[ch] ^ ($urandom & 32'h7) ^ (($urandom % 8 == 0) ? 32'h100 : 0);
        logic [31:0] d = m_data ^ ($urandom & 32'h1f);
        step($urandom % 8 != 0, a, d, 1'($urandom), 1'($urandom), 1'($urandom),
             2'($urandom), 8'($urandom & 3), ($urandom % 3 == 0));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule